// File: doc/BRIEF.md
# Multi-Link Latency Deskew Controller

This block lines up the word streams of several deserialized front-end links so that every channel presents data from the same bunch crossing in the same clock cycle. Each link's receiver settles, after every reset, on one of two latencies that differ by a single clock. The front end sends a periodic orbit marker on every link, and a local reference marker gives the start of each orbit. For each link the controller counts the clocks from the reference marker to that link's marker. If the count is above a per-link acceptable limit, the receiver landed on its longer latency. The controller then pulses a reset request to that receiver and measures again at the next orbit. It repeats this until the short latency is reached or a programmable retry cap runs out.

Once a link locks, its measured offset sets the read pointer of a small circular buffer on that link. Every locked link then comes out a common, configurable number of clocks after the reference marker. A locked link keeps watching its own markers. If a marker comes at any other position, or is missing where it should be, the link raises a sticky out-of-sync flag, which stays set until it is cleared.

Top module: `lane_deskew`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `rx_rst`, `locked`, `failed`, `sync_err`, `al_vld` and `al_mrk` are all zero.
- R2: After `align_go`, each link waits for `ref_mrk`. It counts the clocks from the sampled reference edge to the edge that samples its `lnk_mrk` (a marker k edges later gives offset k). If that offset is at most the link's field `lat_max[i*4 +: 4]`, the link goes to `locked` right after that edge, and `rx_rst` does not pulse.
- R3: If the measured offset is above the link's limit, that link drives `rx_rst[i]` high for exactly one cycle right after the marker edge, ignores markers until the next `ref_mrk`, and then measures again.
- R4: A link that has already issued `retry_max` reset requests and then measures another late marker raises `failed[i]` right after that edge. It issues no further `rx_rst` pulses until the next `align_go`.
- R5: Link i's slice of `lnk_data` is bits `[i*16 +: 16]`. On a locked link, `al_data` and `al_vld` repeat that link's `lnk_data` and `lnk_vld` delayed by `out_lat` minus the link's offset. Every locked link therefore shows, in any cycle, the word the front end sent `out_lat` clocks after the matching reference edge.
- R6: On all locked links, `al_mrk` rises in the same cycle, `out_lat` edges after the reference edge.
- R7: On a locked link, a marker sampled at any count other than the locked offset, or no marker at the locked offset, sets `sync_err[i]`. While markers stay at the locked offset, no error is raised.
- R8: `sync_err` stays set until `err_clr` or `align_go`. A new error in the same cycle as `err_clr` wins.
- R9: On a link that is not locked, `al_vld` and `al_mrk` are zero in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| align_go | input | 1 | Pulse: restart alignment on every link |
| err_clr | input | 1 | Clears all out-of-sync flags |
| ref_mrk | input | 1 | Local orbit reference marker |
| lnk_data | input | NL*DW | Words from each link, link i at [i*DW +: DW] |
| lnk_vld | input | NL | Word valid per link |
| lnk_mrk | input | NL | Orbit marker per link |
| lat_max | input | NL*OW | Largest acceptable offset per link, link i at [i*OW +: OW] |
| out_lat | input | OW | Common output latency after the reference marker |
| retry_max | input | RW | Cap on reset requests per alignment |
| rx_rst | output | NL | One-cycle receiver reset request per link |
| locked | output | NL | Link aligned at its short latency |
| failed | output | NL | Retry cap exhausted |
| sync_err | output | NL | Sticky out-of-sync flag |
| al_data | output | NL*DW | Aligned words |
| al_vld | output | NL | Aligned word valid |
| al_mrk | output | NL | Aligned marker strobe |

## Verification
`rx_rst`, `locked` and `failed` each change in the cycle right after the edge that samples the link marker. The bench therefore checks the orbit phase of each event, as well as its kind, against a per-link queue of expected events. It builds that queue from its own model of which receiver draws land long. Aligned words and markers are due `out_lat` edges after the reference edge that starts their orbit. From each cycle count the bench works out which front-end word must be on the outputs, and it compares only after both edges have passed, sampling at the falling edge. Out-of-sync flags are read a full orbit after a slip is applied or removed, and a few cycles after `err_clr`.

// File: rtl/ldsk_pkg.sv
package ldsk_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_MEAS,
        ST_RST,
        ST_LOCK,
        ST_FAIL
    } lane_st_e;
endpackage

// File: rtl/ldsk_lane_ctl.sv
module ldsk_lane_ctl #(
    parameter int OW = 4,
    parameter int RW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic          err_clr,
    input  logic          ref_mrk,
    input  logic          lnk_mrk,
    input  logic [OW-1:0] lat_max,
    input  logic [RW-1:0] retry_max,
    output logic          rx_rst,
    output logic          locked,
    output logic          failed,
    output logic          serr,
    output logic [OW-1:0] off
);
    import ldsk_pkg::*;

    typedef struct packed {
        lane_st_e      st;
        logic [OW-1:0] cnt;
        logic          armed;
        logic [RW-1:0] tries;
        logic [OW-1:0] off;
        logic          serr;
    } ctl_t;

    ctl_t ctl_q, ctl_d;
    logic late;

    always_comb begin
        ctl_d = ctl_q;
        late  = 1'b0;
        // phase counter: 1 in the cycle after a reference edge, saturating
        if (ref_mrk)
            ctl_d.cnt = OW'(1);
        else if (ctl_q.cnt != '1)
            ctl_d.cnt = ctl_q.cnt + 1'b1;
        if (err_clr)
            ctl_d.serr = 1'b0;
        case (ctl_q.st)
            ST_WAIT: begin
                if (ref_mrk)
                    ctl_d.st = ST_MEAS;
            end
            ST_MEAS: begin
                if (lnk_mrk) begin
                    if (ctl_q.cnt <= lat_max) begin
                        ctl_d.st    = ST_LOCK;
                        ctl_d.off   = ctl_q.cnt;
                        ctl_d.armed = 1'b0;
                    end else begin
                        late = 1'b1;
                    end
                end else if (ctl_q.cnt == '1) begin
                    late = 1'b1;
                end
                if (late) begin
                    if (ctl_q.tries == retry_max) begin
                        ctl_d.st = ST_FAIL;
                    end else begin
                        ctl_d.tries = ctl_q.tries + 1'b1;
                        ctl_d.st    = ST_RST;
                    end
                end
            end
            ST_RST: ctl_d.st = ST_WAIT;
            ST_LOCK: begin
                if (ctl_q.armed && ctl_q.cnt == ctl_q.off) begin
                    ctl_d.armed = 1'b0;
                    if (!lnk_mrk)
                        ctl_d.serr = 1'b1;
                end else if (lnk_mrk) begin
                    ctl_d.serr = 1'b1;
                end
                if (ref_mrk)
                    ctl_d.armed = 1'b1;
            end
            default: ;
        endcase
        if (go) begin
            ctl_d.st    = ST_WAIT;
            ctl_d.tries = '0;
            ctl_d.serr  = 1'b0;
            ctl_d.armed = 1'b0;
            ctl_d.off   = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            ctl_q <= '0;
        else
            ctl_q <= ctl_d;
    end

    assign rx_rst = (ctl_q.st == ST_RST);
    assign locked = (ctl_q.st == ST_LOCK);
    assign failed = (ctl_q.st == ST_FAIL);
    assign serr   = ctl_q.serr;
    assign off    = ctl_q.off;
endmodule

// File: rtl/ldsk_elastic.sv
module ldsk_elastic #(
    parameter int DW    = 16,
    parameter int DEPTH = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [AW-1:0] dly,
    input  logic [DW-1:0] din,
    input  logic          vin,
    input  logic          min,
    output logic [DW-1:0] dout,
    output logic          vout,
    output logic          mout
);
    localparam int EW = DW + 2;

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [DW-1:0] dout;
        logic          vout;
        logic          mout;
    } buf_t;

    buf_t buf_q, buf_d;
    logic [EW-1:0] mem [DEPTH];
    logic [EW-1:0] rd;

    assign rd = mem[buf_q.wp - dly];

    always_comb begin
        buf_d      = buf_q;
        buf_d.wp   = buf_q.wp + 1'b1;
        buf_d.dout = rd[DW-1:0];
        buf_d.vout = en & rd[DW];
        buf_d.mout = en & rd[DW+1];
    end

    always_ff @(posedge clk) begin
        mem[buf_q.wp] <= {min, vin, din};
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            buf_q <= '0;
        else
            buf_q <= buf_d;
    end

    assign dout = buf_q.dout;
    assign vout = buf_q.vout;
    assign mout = buf_q.mout;
endmodule

// File: rtl/lane_deskew.sv
module lane_deskew #(
    parameter int NL    = 4,
    parameter int DW    = 16,
    parameter int DEPTH = 8,
    parameter int OW    = 4,
    parameter int RW    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             align_go,
    input  logic             err_clr,
    input  logic             ref_mrk,
    input  logic [NL*DW-1:0] lnk_data,
    input  logic [NL-1:0]    lnk_vld,
    input  logic [NL-1:0]    lnk_mrk,
    input  logic [NL*OW-1:0] lat_max,
    input  logic [OW-1:0]    out_lat,
    input  logic [RW-1:0]    retry_max,
    output logic [NL-1:0]    rx_rst,
    output logic [NL-1:0]    locked,
    output logic [NL-1:0]    failed,
    output logic [NL-1:0]    sync_err,
    output logic [NL*DW-1:0] al_data,
    output logic [NL-1:0]    al_vld,
    output logic [NL-1:0]    al_mrk
);
    localparam int AW = $clog2(DEPTH);

    for (genvar i = 0; i < NL; i++) begin : g_lane
        logic [OW-1:0] off;
        logic [OW-1:0] gap;

        ldsk_lane_ctl #(.OW(OW), .RW(RW)) u_ctl (
            .clk      (clk),
            .rst_n    (rst_n),
            .go       (align_go),
            .err_clr  (err_clr),
            .ref_mrk  (ref_mrk),
            .lnk_mrk  (lnk_mrk[i]),
            .lat_max  (lat_max[i*OW +: OW]),
            .retry_max(retry_max),
            .rx_rst   (rx_rst[i]),
            .locked   (locked[i]),
            .failed   (failed[i]),
            .serr     (sync_err[i]),
            .off      (off)
        );

        assign gap = out_lat - off;

        ldsk_elastic #(.DW(DW), .DEPTH(DEPTH)) u_buf (
            .clk  (clk),
            .rst_n(rst_n),
            .en   (locked[i]),
            .dly  (gap[AW-1:0]),
            .din  (lnk_data[i*DW +: DW]),
            .vin  (lnk_vld[i]),
            .min  (lnk_mrk[i]),
            .dout (al_data[i*DW +: DW]),
            .vout (al_vld[i]),
            .mout (al_mrk[i])
        );
    end
endmodule

// File: rtl/lane_deskew_chk.sv
module lane_deskew_chk #(
    parameter int NL = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          align_go,
    input logic          err_clr,
    input logic [NL-1:0] rx_rst,
    input logic [NL-1:0] locked,
    input logic [NL-1:0] failed,
    input logic [NL-1:0] sync_err,
    input logic [NL-1:0] al_vld,
    input logic [NL-1:0] al_mrk
);
    for (genvar i = 0; i < NL; i++) begin : g_a
        AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) rx_rst[i] |=> !rx_rst[i]); // R3
        AST_FAIL_HOLDS_QUIET: assert property (@(posedge clk) disable iff (!rst_n) failed[i] && !align_go |=> failed[i] && !rx_rst[i]); // R4
        AST_UNLOCKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !locked[i] |=> !al_vld[i] && !al_mrk[i]); // R9
        AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) sync_err[i] && !err_clr && !align_go |=> sync_err[i]); // R8
        for (genvar j = 0; j < NL; j++) begin : g_b
            AST_COMMON_MARK: assert property (@(posedge clk) disable iff (!rst_n) al_mrk[i] && locked[j] && $past(locked[j]) && !sync_err[i] && !sync_err[j] |-> al_mrk[j]); // R6
        end
    end
endmodule

bind lane_deskew lane_deskew_chk #(.NL(NL)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .align_go(align_go),
    .err_clr (err_clr),
    .rx_rst  (rx_rst),
    .locked  (locked),
    .failed  (failed),
    .sync_err(sync_err),
    .al_vld  (al_vld),
    .al_mrk  (al_mrk)
);

// File: tb/lane_deskew_bench.sv
`timescale 1ns/1ps
module lane_deskew_bench;
    localparam int NL = 4, DW = 16, OW = 4, RW = 4, PER = 16;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic             rst_n, align_go, err_clr, ref_mrk;
    logic [NL*DW-1:0] lnk_data;
    logic [NL-1:0]    lnk_vld, lnk_mrk;
    logic [NL*OW-1:0] lat_max;
    logic [OW-1:0]    out_lat;
    logic [RW-1:0]    retry_max;
    logic [NL-1:0]    rx_rst, locked, failed, sync_err, al_vld, al_mrk;
    logic [NL*DW-1:0] al_data;

    lane_deskew u_lane_deskew (.*);

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int base [NL] = '{1, 2, 3, 4};
    int need [NL] = '{0, 1, 2, 5};
    int resets [NL] = '{0, 0, 0, 0};
    int slip [NL] = '{0, 0, 0, 0};
    int exp_kind [NL][$];
    int exp_ph [NL][$];
    logic [NL-1:0] exp_lock = '0, mask = '0, lk_prev = '0, fl_prev = '0;
    int olat = 9;
    bit chk_en = 0;
    int total = 0, bad = 0;

    function automatic int cur_off(int i);
        return base[i] + ((resets[i] < need[i]) ? 3 : 2) + slip[i];
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // monitor: pop expected event for link i and compare kind and orbit phase
    task automatic mon_evt(int i, int k);
        int ek, ep;
        string rq;
        if (exp_kind[i].size() == 0) begin
            chk(0, "R3", $sformatf("unexpected event on link %0d", i), k, 0);
        end else begin
            ek = exp_kind[i].pop_front();
            ep = exp_ph[i].pop_front();
            rq = (ek == 1) ? "R3" : (ek == 2) ? "R2" : "R4";
            chk(k == ek && (cyc % PER) == ep, rq, $sformatf("link %0d event*100+phase", i),
                k * 100 + cyc % PER, ek * 100 + ep);
        end
    endtask

    always @(negedge clk) begin
        int s, st;
        if (rst_n) begin
            for (int i = 0; i < NL; i++) begin
                if (rx_rst[i]) begin
                    mon_evt(i, 1);
                    resets[i]++;
                end
                if (locked[i] && !lk_prev[i]) mon_evt(i, 2);
                if (failed[i] && !fl_prev[i]) mon_evt(i, 3);
            end
        end
        lk_prev = locked;
        fl_prev = failed;
        if (chk_en) begin
            for (int i = 0; i < NL; i++) begin
                st = cyc + 64 - olat;
                if (exp_lock[i] && !mask[i]) begin
                    chk(al_data[i*DW +: DW] == DW'(st), "R5", $sformatf("link %0d data", i),
                        int'(al_data[i*DW +: DW]), st % 65536);
                    chk(al_vld[i] == (st % 5 != 3), "R5", $sformatf("link %0d valid", i),
                        int'(al_vld[i]), int'(st % 5 != 3));
                    chk(al_mrk[i] == (st % PER == 0), "R6", $sformatf("link %0d marker", i),
                        int'(al_mrk[i]), int'(st % PER == 0));
                end else if (!exp_lock[i]) begin
                    chk(!al_vld[i] && !al_mrk[i], "R9", $sformatf("link %0d quiet", i),
                        int'({al_vld[i], al_mrk[i]}), 0);
                end
            end
        end
        s = cyc + 1;
        ref_mrk = (s % PER == 0);
        for (int i = 0; i < NL; i++) begin
            st = s + 64 - cur_off(i);
            lnk_data[i*DW +: DW] = DW'(st);
            lnk_vld[i] = (st % 5 != 3);
            lnk_mrk[i] = (st % PER == 0);
        end
    end

    // driver: predict each link's event sequence, then start alignment
    task automatic plan_run(int rmax, int lat_out);
        int n;
        bit busy;
        chk_en = 0;
        for (int i = 0; i < NL; i++) begin
            n = need[i] - resets[i];
            if (n < 0) n = 0;
            for (int k = 0; k < ((n <= rmax) ? n : rmax); k++) begin
                exp_kind[i].push_back(1);
                exp_ph[i].push_back(base[i] + 3);
            end
            if (n <= rmax) begin
                exp_kind[i].push_back(2);
                exp_ph[i].push_back(base[i] + 2);
                exp_lock[i] = 1'b1;
            end else begin
                exp_kind[i].push_back(3);
                exp_ph[i].push_back(base[i] + 3);
                exp_lock[i] = 1'b0;
            end
        end
        @(negedge clk);
        olat = lat_out;
        out_lat = OW'(lat_out);
        retry_max = RW'(rmax);
        align_go = 1'b1;
        @(negedge clk);
        align_go = 1'b0;
        busy = 1;
        while (busy) begin
            @(negedge clk);
            busy = 0;
            for (int i = 0; i < NL; i++) if (exp_kind[i].size() != 0) busy = 1;
        end
        repeat (2 * PER) @(negedge clk);
        chk_en = 1;
        repeat (100) @(negedge clk);
    endtask

    initial begin
        repeat (30000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        align_go = 1'b0;
        err_clr = 1'b0;
        out_lat = '0;
        retry_max = '0;
        for (int i = 0; i < NL; i++) lat_max[i*OW +: OW] = OW'(base[i] + 2);
        repeat (5) @(negedge clk);
        chk({rx_rst, locked, failed, sync_err, al_vld, al_mrk} == '0, "R1", "outputs in reset", 1, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({rx_rst, locked, failed, sync_err, al_vld, al_mrk} == '0, "R1", "outputs after reset", 1, 0);

        // run 1: cap 3, link 3 exhausts retries (R2 R3 R4)
        plan_run(3, 9);
        chk(failed == 4'b1000, "R4", "failed mask", int'(failed), 8);
        // run 2: larger cap and latency, all links lock
        plan_run(7, 10);
        chk(locked == 4'b1111, "R2", "locked mask", int'(locked), 15);
        chk(sync_err == '0, "R7", "no error while aligned", int'(sync_err), 0);

        // out-of-sync on link 1
        mask[1] = 1'b1;
        slip[1] = 1;
        repeat (2 * PER + 4) @(negedge clk);
        chk(sync_err == 4'b0010, "R7", "slip flagged", int'(sync_err), 2);
        slip[1] = 0;
        repeat (2 * PER + 4) @(negedge clk);
        chk(sync_err == 4'b0010, "R8", "flag sticky", int'(sync_err), 2);
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
        repeat (2) @(negedge clk);
        chk(sync_err == '0, "R8", "flag cleared", int'(sync_err), 0);
        repeat (2 * PER + 4) @(negedge clk);
        chk(sync_err == '0, "R7", "no error after realign", int'(sync_err), 0);
        mask[1] = 1'b0;
        repeat (60) @(negedge clk);

        for (int i = 0; i < NL; i++)
            chk(exp_kind[i].size() == 0, "R4", $sformatf("link %0d pending events", i),
                exp_kind[i].size(), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule